// File: doc/BRIEF.md
# Two-Wire Write Master with Counted Transfers

This block drives a two-wire serial bus as a write-only master. Software first sets a 7-bit target address. It may then queue the first payload byte in a small transmit queue. Last, it writes a control word that carries the number of payload bytes and a go bit. The engine then produces a START condition, the address byte with the write bit clear and one payload byte per slot, sampling the acknowledge after each byte. A STOP follows the programmed number of payload bytes.

The payload is pulled from software on demand. A write-one-to-clear service flag is raised whenever the queue has room for a byte that is still owed. A separate completion flag marks the end of the transfer. An error flag is raised when the target refuses a byte. If a byte is due and the queue is empty, the engine parks with the clock line held low until software supplies the byte. Both bus lines are open-drain: each output port, when high, pulls its line low.

Top module: `i2cw_master`

## Requirements
- R1: After reset both bus lines are released, and the address register (offset 0), the control register (offset 2), the status register (offset 3) and the queue-level register (offset 4) all read zero.
- R2: Writing offset 2 with bit 0 set starts a transfer using the byte count held in bits 13:6. The bus then shows START, the byte {address, 0}, the queued bytes in the order they were written, and STOP.
- R3: A byte written to offset 1 before the go bit is set is the first payload byte sent.
- R4: Status bit 0 (service) is set in two cases: when a transfer starts while fewer bytes have been written than the count and the queue is not full, and each time a byte leaves the queue while fewer bytes have been written than the count. Writing 1 to a status bit clears it.
- R5: Status bit 1 (complete) is set when the STOP has finished, and at that moment control bit 0 reads back zero.
- R6: If the data line is high during the ninth clock of a byte (a refusal), the engine issues STOP, sets status bits 2 and 1, and empties the queue, so that offset 4 reads zero.
- R7: Offset 4 reads 0 when the queue is empty, 1 when it holds one byte and 2 when it is full (two bytes). A write to offset 1 while the queue is full is dropped.
- R8: Each clock-high phase of a bit lasts 2*CLK_DIV cycles. The data line changes while the clock line is high only at START and STOP, so each transfer shows exactly one START and one STOP.
- R9: When a payload byte is due and the queue is empty, the clock line stays low and no further bits appear until a byte is written.
- R10: A write to offset 2 while a transfer is in progress has no effect on the byte count.
- R11: A count of zero sends the address byte followed directly by STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset for reads and writes |
| bus_wdata | input | 14 | Register write data |
| bus_rdata | output | 14 | Register read data for bus_addr (combinational) |
| scl_oe | output | 1 | Pull the clock line low when 1 |
| sda_oe | output | 1 | Pull the data line low when 1 |
| sda_i | input | 1 | Sensed level of the data line |

## Verification
The bench decodes the bus lines the way a target would and acknowledges or refuses chosen bytes. It checks the following corner cases:
- A zero count. A design that got this wrong would send a stray payload byte.
- A transfer with no preloaded byte and a slow response from software. A design that got this wrong would clock out garbage instead of parking with the clock low.
- Refusal of the address byte with a full queue. A design that got this wrong would leave stale bytes for the next transfer.
- A third write into a full queue. A design that got this wrong would corrupt the order of the bytes.
- A control rewrite in mid-transfer. A design that got this wrong would change the length of the transfer.

Random transfers compare the number of service events against the count minus the preloaded bytes. An extra or missing service event would stall software or overrun the queue.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
   localparam logic [2:0] REG_TADDR = 3'd0;
   localparam logic [2:0] REG_TXD   = 3'd1;
   localparam logic [2:0] REG_CTRL  = 3'd2;
   localparam logic [2:0] REG_STAT  = 3'd3;
   localparam logic [2:0] REG_LVL   = 3'd4;
   localparam int CNT_LSB = 6;
   localparam int ADDR_W  = 7;
   typedef enum logic [2:0] {
      E_IDLE, E_START, E_BIT, E_WAIT, E_STOP
   } eng_st_e;
endpackage

// File: rtl/i2cw_tick.sv
module i2cw_tick #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int W = $clog2(DIV);
   logic [W-1:0] cnt;

   assign tick = run && (cnt == W'(DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (!run)   cnt <= '0;
      else if (tick)   cnt <= '0;
      else             cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/i2cw_txq.sv
module i2cw_txq #(
   parameter int DEPTH = 2,
   parameter int DW = 8,
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   input  logic          flush,
   output logic [DW-1:0] rdata,
   output logic          empty,
   output logic          full,
   output logic [LW-1:0] level
);
   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] rp, wp, rp_nx, wp_nx;
   logic do_push, do_pop;

   assign empty   = (level == '0);
   assign full    = (level == LW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rp];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign rp_nx = rp + 1'b1;
         assign wp_nx = wp + 1'b1;
      end else begin : g_wrap
         assign rp_nx = (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
         assign wp_nx = (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wp] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rp <= '0; wp <= '0; level <= '0;
      end else if (flush) begin
         rp <= '0; wp <= '0; level <= '0;
      end else begin
         if (do_push) wp <= wp_nx;
         if (do_pop)  rp <= rp_nx;
         level <= level + LW'(do_push) - LW'(do_pop);
      end
   end
endmodule

// File: rtl/i2cw_engine.sv
module i2cw_engine import i2cw_pkg::*; #(
   parameter int CW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] taddr,
   input  logic [CW-1:0]     count,
   input  logic              tick,
   input  logic              q_empty,
   input  logic [7:0]        q_data,
   input  logic              sda_i,
   output logic              pop,
   output logic              busy,
   output logic              stall,
   output logic              scl_oe,
   output logic              sda_oe,
   output logic              done_p,
   output logic              nack_p
);
   eng_st_e st;
   logic [1:0]    q;
   logic [3:0]    bitn;
   logic [7:0]    sh;
   logic [CW-1:0] left;
   logic          nack_r, sda_nx, slot_end, ack_ok;

   assign slot_end = (st == E_BIT) && tick && (q == 2'd3) && (bitn == 4'd8);
   assign ack_ok   = slot_end && !sda_i;
   assign pop      = (ack_ok && (left != '0) && !q_empty) || ((st == E_WAIT) && !q_empty);
   assign busy     = (st != E_IDLE);
   assign stall    = (st == E_WAIT);
   assign done_p   = (st == E_STOP) && tick && (q == 2'd3);
   assign nack_p   = done_p && nack_r;

   always_comb begin
      scl_oe = 1'b0;
      sda_nx = 1'b0;
      case (st)
         E_START: begin scl_oe = (q >= 2'd2); sda_nx = (q >= 2'd1); end
         E_BIT:   begin scl_oe = (q < 2'd2);  sda_nx = (bitn != 4'd8) && !sh[7]; end
         E_WAIT:  begin scl_oe = 1'b1;        sda_nx = 1'b0; end
         E_STOP:  begin scl_oe = (q == 2'd0); sda_nx = (q < 2'd2); end
         default: begin scl_oe = 1'b0;        sda_nx = 1'b0; end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= E_IDLE; q <= '0; bitn <= '0; sh <= '0;
         left <= '0; nack_r <= 1'b0; sda_oe <= 1'b0;
      end else begin
         sda_oe <= sda_nx;
         case (st)
            E_IDLE: if (start) begin
               st <= E_START; q <= '0; sh <= {taddr, 1'b0};
               left <= count; nack_r <= 1'b0;
            end
            E_START: if (tick) begin
               if (q == 2'd3) begin st <= E_BIT; q <= '0; bitn <= '0; end
               else q <= q + 2'd1;
            end
            E_BIT: if (tick) begin
               if (q != 2'd3) q <= q + 2'd1;
               else begin
                  q <= '0;
                  if (bitn != 4'd8) begin
                     bitn <= bitn + 4'd1;
                     sh   <= {sh[6:0], 1'b0};
                  end else if (sda_i) begin
                     nack_r <= 1'b1; st <= E_STOP;
                  end else if (left == '0) st <= E_STOP;
                  else if (q_empty)        st <= E_WAIT;
                  else begin
                     sh <= q_data; left <= left - 1'b1; bitn <= '0;
                  end
               end
            end
            E_WAIT: if (!q_empty) begin
               st <= E_BIT; q <= '0; bitn <= '0;
               sh <= q_data; left <= left - 1'b1;
            end
            E_STOP: if (tick) begin
               if (q == 2'd3) st <= E_IDLE;
               else q <= q + 2'd1;
            end
            default: st <= E_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/i2cw_master.sv
module i2cw_master import i2cw_pkg::*; #(
   parameter int CLK_DIV    = 4,
   parameter int FIFO_DEPTH = 2,
   parameter int CNT_W      = 8,
   localparam int BW = CNT_LSB + CNT_W,
   localparam int LW = $clog2(FIFO_DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic [2:0]    bus_addr,
   input  logic [BW-1:0] bus_wdata,
   output logic [BW-1:0] bus_rdata,
   output logic          scl_oe,
   output logic          sda_oe,
   input  logic          sda_i
);
   generate
      if (CLK_DIV < 2) begin : g_bad_div
         $error("CLK_DIV must be at least 2");
      end
      if (FIFO_DEPTH < 1) begin : g_bad_depth
         $error("FIFO_DEPTH must be at least 1");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
   endgenerate

   logic [ADDR_W-1:0] taddr_r;
   logic [CNT_W-1:0]  cnt_r, wr_cnt;
   logic              go_r, kick, st_svc, st_done, st_nack;
   logic              wr_txd, wr_ctrl, wr_stat, owed;
   logic              tick, pop, busy, stall, done_p, nack_p;
   logic              q_empty, q_full;
   logic [7:0]        q_data;
   logic [LW-1:0]     q_level;
   logic [1:0]        lvl_code;
   logic              svc_set;

   assign wr_txd  = bus_wr && (bus_addr == REG_TXD);
   assign wr_ctrl = bus_wr && (bus_addr == REG_CTRL) && bus_wdata[0] && !go_r;
   assign wr_stat = bus_wr && (bus_addr == REG_STAT);
   assign owed    = (wr_cnt < cnt_r);
   assign svc_set = (kick && owed && !q_full) || (pop && owed);

   i2cw_txq #(.DEPTH(FIFO_DEPTH), .DW(8)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(wr_txd), .wdata(bus_wdata[7:0]),
      .pop(pop), .flush(done_p), .rdata(q_data), .empty(q_empty),
      .full(q_full), .level(q_level)
   );

   i2cw_tick #(.DIV(CLK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(busy && !stall), .tick(tick)
   );

   i2cw_engine #(.CW(CNT_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .start(kick), .taddr(taddr_r), .count(cnt_r),
      .tick(tick), .q_empty(q_empty), .q_data(q_data), .sda_i(sda_i),
      .pop(pop), .busy(busy), .stall(stall), .scl_oe(scl_oe), .sda_oe(sda_oe),
      .done_p(done_p), .nack_p(nack_p)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         taddr_r <= '0; cnt_r <= '0; wr_cnt <= '0; go_r <= 1'b0; kick <= 1'b0;
         st_svc <= 1'b0; st_done <= 1'b0; st_nack <= 1'b0;
      end else begin
         kick <= wr_ctrl;
         if (bus_wr && (bus_addr == REG_TADDR)) taddr_r <= bus_wdata[ADDR_W-1:0];
         if (wr_ctrl) begin
            go_r  <= 1'b1;
            cnt_r <= bus_wdata[CNT_LSB +: CNT_W];
         end else if (done_p) go_r <= 1'b0;
         if (done_p) wr_cnt <= '0;
         else if (wr_txd && !q_full && (wr_cnt != '1)) wr_cnt <= wr_cnt + 1'b1;
         st_svc  <= svc_set | (st_svc  & ~(wr_stat & bus_wdata[0]));
         st_done <= done_p  | (st_done & ~(wr_stat & bus_wdata[1]));
         st_nack <= nack_p  | (st_nack & ~(wr_stat & bus_wdata[2]));
      end
   end

   assign lvl_code = (q_level == LW'(FIFO_DEPTH)) ? 2'd2 :
                     (q_level == '0) ? 2'd0 : 2'd1;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         REG_TADDR: bus_rdata[ADDR_W-1:0] = taddr_r;
         REG_CTRL: begin
            bus_rdata[0] = go_r;
            bus_rdata[CNT_LSB +: CNT_W] = cnt_r;
         end
         REG_STAT: bus_rdata[2:0] = {st_nack, st_done, st_svc};
         REG_LVL:  bus_rdata[1:0] = lvl_code;
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/i2cw_checker.sv
module i2cw_checker #(
   parameter int DEPTH = 2,
   localparam int LW = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          stall,
   input logic          scl_oe,
   input logic          sda_oe,
   input logic          go,
   input logic          done_p,
   input logic          st_done,
   input logic          st_nack,
   input logic [LW-1:0] lvl
);
   p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(!busy)) |-> (!scl_oe && !sda_oe));

   p_done_drops_go_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_p |=> !go);

   p_nack_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_nack) |-> st_done);

   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lvl <= LW'(DEPTH));

   p_hold_clock_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> scl_oe);
endmodule

bind i2cw_master i2cw_checker #(.DEPTH(FIFO_DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .stall(stall), .scl_oe(scl_oe),
   .sda_oe(sda_oe), .go(go_r), .done_p(done_p), .st_done(st_done),
   .st_nack(st_nack), .lvl(q_level)
);

// File: tb/tb_i2cw_master.sv
`timescale 1ns/1ps
module tb_i2cw_master;
   localparam int DIV = 3;
   localparam int BW  = 14;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          bus_wr = 1'b0;
   logic [2:0]    bus_addr = '0;
   logic [BW-1:0] bus_wdata = '0;
   logic [BW-1:0] bus_rdata;
   logic          scl_oe, sda_oe, sda_i;
   logic          tgt_pull = 1'b0;

   assign sda_i = ~(sda_oe | tgt_pull);

   i2cw_master #(.CLK_DIV(DIV), .FIFO_DEPTH(2), .CNT_W(8)) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .scl_oe(scl_oe),
      .sda_oe(sda_oe), .sda_i(sda_i)
   );

   int nchk = 0, nfail = 0;
   logic [7:0] tx [16];
   logic [7:0] mon_byte [16];
   logic [7:0] mon_sh = '0;
   int mon_bc = 0, mon_nb = 0, mon_starts = 0, mon_stops = 0;
   int nack_at = -1, hi_cnt = 0, duty_err = 0;
   bit hi_valid = 1'b0, pscl = 1'b1, psda = 1'b1;

   // Bus-side target model and decoder, sampled on the falling clock edge
   always @(negedge clk) begin
      bit scl, sda;
      if (rst_n) begin
         scl = !scl_oe;
         sda = sda_i;
         if (scl && pscl && psda && !sda) begin
            mon_starts++; mon_bc = 0;
         end else if (scl && pscl && !psda && sda) begin
            mon_stops++; hi_valid = 1'b0;
         end else if (scl && !pscl) begin
            hi_valid = 1'b1; hi_cnt = 0;
            if (mon_bc == 8) begin
               if (mon_nb < 16) mon_byte[mon_nb] = mon_sh;
               mon_nb++; mon_bc = 0;
            end else begin
               mon_sh = {mon_sh[6:0], sda}; mon_bc++;
            end
         end
         if (!scl && pscl) begin
            if (hi_valid && hi_cnt != 2 * DIV) duty_err++;
            hi_valid = 1'b0;
            tgt_pull = (mon_bc == 8) && (nack_at != mon_nb);
         end
         if (scl) hi_cnt++;
         pscl = scl; psda = sda;
      end
   end

   task automatic check_eq(input string req, input string what, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic bwrite(input logic [2:0] a, input int d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = BW'(d);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bread(input logic [2:0] a, output int d);
      @(negedge clk);
      bus_addr = a;
      #1 d = int'(bus_rdata);
   endtask

   function automatic int accepted(input int pre);
      return (pre > 2) ? 2 : pre;
   endfunction

   function automatic bit refused(input int nk, input int n);
      return (nk >= 0) && (nk <= n);
   endfunction

   task automatic run_xfer(input logic [6:0] addr, input int n, input int pre,
                           input int nk, input int lag, input bit poke);
      int acc, wcount, svc_seen, nb_exp, guard, s;
      bit first, pend;
      for (int i = 0; i < 16; i++) tx[i] = 8'($urandom);
      mon_nb = 0; mon_bc = 0; mon_starts = 0; mon_stops = 0;
      duty_err = 0; nack_at = nk;
      bwrite(3'd0, int'(addr));
      for (int i = 0; i < pre; i++) bwrite(3'd1, int'(tx[i]));
      acc = accepted(pre);
      bread(3'd4, s);
      check_eq("R7", "queue level after preload", s, acc);
      wcount = acc;
      bwrite(3'd2, (n << 6) | 1);
      svc_seen = 0; first = 1'b1; pend = poke; guard = 0;
      while (guard < 20000) begin
         guard++;
         bread(3'd3, s);
         if (s[1]) break;
         if (s[0]) begin
            svc_seen++;
            if (first && lag > 0) begin
               repeat (lag) @(negedge clk);
               check_eq("R9", "clock held low while queue empty", int'(scl_oe), 1);
               check_eq("R9", "bytes seen while parked", mon_nb, 1);
               check_eq("R9", "stray bits while parked", mon_bc, 0);
            end
            first = 1'b0;
            bwrite(3'd3, 1);
            if (pend) begin
               bwrite(3'd2, (7 << 6) | 1);
               pend = 1'b0;
            end
            if (wcount < n) begin
               bwrite(3'd1, int'(tx[wcount]));
               wcount++;
            end
         end
      end
      repeat (4) @(negedge clk);
      nb_exp = refused(nk, n) ? nk + 1 : n + 1;
      check_eq((n == 0) ? "R11" : "R2", "bytes on bus", mon_nb, nb_exp);
      check_eq("R2", "address byte", int'(mon_byte[0]), int'({addr, 1'b0}));
      for (int k = 1; k < nb_exp && k < 16; k++)
         check_eq((k == 1 && pre > 0) ? "R3" : "R2", "payload byte",
                  int'(mon_byte[k]), int'(tx[k-1]));
      check_eq("R8", "START count", mon_starts, 1);
      check_eq("R8", "STOP count", mon_stops, 1);
      check_eq("R8", "clock-high width errors", duty_err, 0);
      bread(3'd3, s);
      check_eq("R5", "complete flag", s & 2, 2);
      check_eq("R6", "refusal flag", (s >> 2) & 1, int'(refused(nk, n)));
      if (!refused(nk, n)) check_eq("R4", "service events", svc_seen, n - acc);
      bread(3'd2, s);
      check_eq("R5", "go bit after end", s & 1, 0);
      if (poke) check_eq("R10", "count after busy rewrite", (s >> 6) & 255, n);
      bread(3'd4, s);
      check_eq("R6", "queue level after end", s, 0);
      bwrite(3'd3, 7);
      bread(3'd3, s);
      check_eq("R4", "status after write-one-clear", s, 0);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL R2 watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      int s;
      void'($urandom(32'h5EED_0042));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      check_eq("R1", "clock pull after reset", int'(scl_oe), 0);
      check_eq("R1", "data pull after reset", int'(sda_oe), 0);
      bread(3'd0, s); check_eq("R1", "address reg", s, 0);
      bread(3'd2, s); check_eq("R1", "control reg", s, 0);
      bread(3'd3, s); check_eq("R1", "status reg", s, 0);
      bread(3'd4, s); check_eq("R1", "level reg", s, 0);

      run_xfer(7'h50, 0, 0, -1, 0, 1'b0);   // R11 address only
      run_xfer(7'h2A, 2, 1, -1, 0, 1'b0);   // R3 preload then one on demand
      run_xfer(7'h11, 1, 0, -1, 300, 1'b0); // R9 parked clock
      run_xfer(7'h33, 3, 1, -1, 0, 1'b1);   // R10 busy rewrite
      run_xfer(7'h44, 2, 3, -1, 0, 1'b0);   // R7 third write dropped
      run_xfer(7'h55, 3, 2, 0, 0, 1'b0);    // R6 address refused, queue flushed
      run_xfer(7'h66, 4, 1, 2, 0, 1'b0);    // R6 data refused
      for (int r = 0; r < 10; r++) begin
         int n, pre, nk;
         n   = $urandom_range(0, 5);
         pre = (n == 0) ? 0 : $urandom_range(0, (n > 2) ? 2 : n);
         nk  = ($urandom_range(0, 3) == 0) ? $urandom_range(0, n) : -1;
         run_xfer(7'($urandom), n, pre, nk, 0, 1'b0);
      end
      finish_run();
   end
endmodule